// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block drives the feedback divider of a frequency synthesizer with a slowly varying offset code, so that the synthesized clock sweeps back and forth across a chosen band and its spectral peaks are lowered. It runs on the reference clock. It produces a signed offset relative to nominal frequency that follows a triangular path with a fixed rate. The sweep amplitude can be selected. A mode bit picks either a one-sided downward sweep that never rises above nominal, or a sweep centred on nominal. A two-bit width code picks one of four amplitudes.

The offset is given in units of 0.005 % of nominal frequency, so two LSBs equal one part per ten thousand. This unit is fine enough to represent the smallest centred amplitude (±0.625 %) exactly. When the active-low enable is high, the offset is held at zero and the synthesizer runs at nominal frequency. A new mode or width selection is taken in only when the sweep returns to its nominal point at the end of a period, so the sweep never jumps. A separate reference bit is passed straight through and never carries any modulation.

Top module: `ss_profile_gen`

## Requirements
- R1: With center_i = 0, the offset sweeps between 0 (100 % of nominal) and -(250 << width_i) LSB, which is 98.75 %, 97.5 %, 95 % or 90 % of nominal for width_i = 00, 01, 10, 11. The minimum is reached PERIOD/2 cycles into the period.
- R2: With center_i = 1, the offset sweeps between -(125 << width_i) and +(125 << width_i) LSB (±0.625 %, ±1.25 %, ±2.5 %, ±5 %). The minimum is reached PERIOD/4 cycles into the period and the maximum at 3·PERIOD/4.
- R3: While spread_n_i is 1, offset_o is 0 and spread_on_o is 0. When spread_n_i rises during a sweep, both reach these values at the second clock edge that samples it high.
- R4: At position m within a period, the offset is base − floor(span·d / (PERIOD/2)). Here span = 250 << width_i and d is the triangular distance of the phase from 0. The phase is m for down mode and (m + PERIOD/4) mod PERIOD for centred mode, and base is span/2 in centred mode and 0 in down mode.
- R5: While spread is active, consecutive offset values move in one direction over each half of the sweep. They differ by at most ceil(4000/PERIOD) LSB, which is 4 at the default PERIOD.
- R6: A change of center_i or width_i while spread is active takes effect only from the next period boundary.
- R7: Every period, including the first one after enable, starts at offset 0. The position-m value appears on offset_o at the (m+2)-th clock edge counted from the first edge that samples spread_n_i low.
- R8: valid_o is 1 in exactly those cycles in which offset_o differs from its value in the previous cycle.
- R9: ref_o always equals ref_i, whatever the state of spread_n_i.
- R10: While rst_ni is low, offset_o, valid_o and spread_on_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_n_i | input | 1 | Spread enable, active low |
| center_i | input | 1 | 0: down sweep, 1: centred sweep |
| width_i | input | 2 | Amplitude select |
| ref_i | input | 1 | Unmodulated reference in |
| offset_o | output | OW | Signed offset, LSB = 0.005 % of nominal |
| valid_o | output | 1 | High in cycles where offset_o changed |
| spread_on_o | output | 1 | Sweep running |
| ref_o | output | 1 | Unmodulated reference out |

## Verification
There is a two-register path from the enable input to the output. As a result, the offset for period position m is due at the (m+2)-th edge after enable is first sampled low, and a disable is seen at the second edge. The bench drives every input on a falling edge. It counts exactly that many rising edges and then samples on the next falling edge, so each expected value is compared in the cycle in which it becomes valid. Deferred configuration, the strobe and step-size checks are made cycle by cycle over full periods, using the same edge counting.

// File: rtl/ss_profile_pkg.sv
package ss_profile_pkg;
  localparam int unsigned WSEL_W = 2;

  typedef struct packed {
    logic              center;
    logic [WSEL_W-1:0] width;
  } ss_cfg_t;
endpackage

// File: rtl/ss_phase_ctr.sv
module ss_phase_ctr
  import ss_profile_pkg::*;
#(
  parameter int unsigned PERIOD = 1024,
  localparam int unsigned CW = $clog2(PERIOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  ss_cfg_t       cfg_i,
  output logic          active_o,
  output logic [CW-1:0] pos_o,
  output ss_cfg_t       cfg_o
);
  logic load_cfg;
  logic wrap;

  assign wrap     = (pos_o == CW'(PERIOD - 1));
  // config tracks inputs while idle, then only at the period boundary
  assign load_cfg = !en_i || !active_o || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      pos_o    <= '0;
      cfg_o    <= '0;
    end else begin
      if (!en_i) begin
        active_o <= 1'b0;
        pos_o    <= '0;
      end else begin
        active_o <= 1'b1;
        pos_o    <= active_o ? pos_o + 1'b1 : '0;
      end
      if (load_cfg) cfg_o <= cfg_i;
    end
  end
endmodule

// File: rtl/ss_tri_map.sv
module ss_tri_map
  import ss_profile_pkg::*;
#(
  parameter int unsigned PERIOD    = 1024,
  parameter int unsigned UNIT_SPAN = 250,
  parameter int unsigned OW        = 16,
  localparam int unsigned CW  = $clog2(PERIOD),
  localparam int unsigned SPW = $clog2(UNIT_SPAN + 1) + 3,
  localparam int unsigned PW  = SPW + CW
) (
  input  logic [CW-1:0]        pos_i,
  input  ss_cfg_t              cfg_i,
  output logic signed [OW-1:0] offset_o
);
  logic [CW-1:0]     phase;
  logic [CW-1:0]     fold;
  logic [PW-1:0]     span;
  logic [PW-1:0]     prod;
  logic [PW-1:0]     scaled;
  logic [PW-1:0]     base;
  logic signed [PW:0] diff;

  always_comb begin
    // centred mode is rotated a quarter period so both modes start at zero
    phase    = pos_i + (cfg_i.center ? CW'(PERIOD / 4) : CW'(0));
    fold     = phase[CW-1] ? (CW'(0) - phase) : phase;
    span     = PW'(UNIT_SPAN) << cfg_i.width;
    prod     = span * PW'(fold);
    scaled   = prod >> (CW - 1);
    base     = cfg_i.center ? (span >> 1) : '0;
    diff     = $signed({1'b0, base}) - $signed({1'b0, scaled});
    offset_o = OW'(diff);
  end
endmodule

// File: rtl/ss_profile_gen.sv
module ss_profile_gen
  import ss_profile_pkg::*;
#(
  parameter int unsigned PERIOD    = 1024,
  parameter int unsigned UNIT_SPAN = 250,
  parameter int unsigned OW        = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 spread_n_i,
  input  logic                 center_i,
  input  logic [WSEL_W-1:0]    width_i,
  input  logic                 ref_i,
  output logic signed [OW-1:0] offset_o,
  output logic                 valid_o,
  output logic                 spread_on_o,
  output logic                 ref_o
);
  localparam int unsigned CW = $clog2(PERIOD);

  ss_cfg_t              cfg_in;
  ss_cfg_t              cfg_q;
  logic                 active;
  logic [CW-1:0]        pos;
  logic signed [OW-1:0] map_off;
  logic signed [OW-1:0] next_off;

  assign cfg_in.center = center_i;
  assign cfg_in.width  = width_i;

  ss_phase_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (!spread_n_i),
    .cfg_i    (cfg_in),
    .active_o (active),
    .pos_o    (pos),
    .cfg_o    (cfg_q)
  );

  ss_tri_map #(.PERIOD(PERIOD), .UNIT_SPAN(UNIT_SPAN), .OW(OW)) u_map (
    .pos_i    (pos),
    .cfg_i    (cfg_q),
    .offset_o (map_off)
  );

  assign next_off = active ? map_off : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o    <= '0;
      valid_o     <= 1'b0;
      spread_on_o <= 1'b0;
    end else begin
      offset_o    <= next_off;
      valid_o     <= (next_off != offset_o);
      spread_on_o <= active;
    end
  end

  assign ref_o = ref_i;
endmodule

// File: rtl/ss_profile_chk.sv
module ss_profile_chk #(
  parameter int unsigned PERIOD    = 1024,
  parameter int unsigned UNIT_SPAN = 250,
  parameter int unsigned OW        = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic signed [OW-1:0] offset_o,
  input logic                 valid_o,
  input logic                 spread_on_o
);
  localparam int MAX_STEP = int'(((UNIT_SPAN << 3) * 2 + PERIOD - 1) / PERIOD);
  localparam int LO       = -int'(UNIT_SPAN << 3);
  localparam int HI       = int'((UNIT_SPAN << 3) / 2);

  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spread_on_o |-> (offset_o == '0));

  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(offset_o) >= LO) && (int'(offset_o) <= HI));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spread_on_o && $past(spread_on_o)) |->
      ((int'(offset_o) - int'($past(offset_o)) <= MAX_STEP) &&
       (int'(offset_o) - int'($past(offset_o)) >= -MAX_STEP)));

  p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spread_on_o) |-> (offset_o == '0));

  p_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (offset_o != $past(offset_o)));
endmodule

bind ss_profile_gen ss_profile_chk #(
  .PERIOD(PERIOD), .UNIT_SPAN(UNIT_SPAN), .OW(OW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .offset_o    (offset_o),
  .valid_o     (valid_o),
  .spread_on_o (spread_on_o)
);

// File: tb/ss_profile_gen_test.sv
`timescale 1ns/1ps
module ss_profile_gen_test;
  localparam int P  = 1024;
  localparam int H  = P / 2;
  localparam int NV = 11;
  // {center, width, position, expected}
  localparam int VEC [NV][4] = '{
    '{0, 0, 512, -250}, '{0, 1, 512, -500}, '{0, 2, 512, -1000},
    '{0, 3, 512, -2000}, '{1, 0, 256, -125}, '{1, 1, 768, 250},
    '{1, 2, 256, -500}, '{1, 3, 768, 1000}, '{0, 3, 256, -1000},
    '{1, 0, 512, 0},    '{0, 2, 100, -195}
  };

  logic clk = 0, rst_ni = 0, spread_n = 1, center = 0, ref_in = 0;
  logic [1:0] width = 0;
  logic signed [15:0] offset;
  logic valid, spread_on, ref_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ss_profile_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .spread_n_i(spread_n), .center_i(center),
    .width_i(width), .ref_i(ref_in), .offset_o(offset), .valid_o(valid),
    .spread_on_o(spread_on), .ref_o(ref_out)
  );

  function automatic int model(int c, int w, int m);
    int span = 250 << w;
    int ph = c ? (m + P / 4) % P : m % P;
    int d = (ph < H) ? ph : P - ph;
    return (c ? span / 2 : 0) - (span * d) / H;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // enable at a falling edge, then sit at position 0 sample point
  task automatic start(input int c, input int w);
    @(negedge clk); spread_n = 1; center = c[0]; width = w[1:0];
    repeat (2) @(negedge clk);
    spread_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int errs, prev, pulses;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 offset", offset, 0);
    chk("R10 valid", valid, 0);
    chk("R10 spread_on", spread_on, 0);
    rst_ni = 1;

    // R3 disabled: config changes have no effect
    errs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      center = i[0]; width = i[2:1];
      if (offset != 0 || spread_on != 0) errs++;
    end
    chk("R3 held at nominal", errs, 0);

    // R1 R2 R4 vector table
    for (int v = 0; v < NV; v++) begin
      start(VEC[v][0], VEC[v][1]);
      adv(VEC[v][2]);
      chk(VEC[v][0] ? "R2 R4 centred point" : "R1 R4 down point", offset, VEC[v][3]);
    end

    // R7 start at nominal
    start(1, 2);
    chk("R7 first value", offset, 0);
    chk("R7 spread_on", spread_on, 1);

    // R5 monotone and bounded step, down width 3
    start(0, 3);
    errs = 0; prev = offset;
    for (int m = 1; m < P; m++) begin
      adv(1);
      if (m <= H) begin
        if (offset > prev || prev - offset > 4) errs++;
      end else begin
        if (offset < prev || offset - prev > 4) errs++;
      end
      prev = offset;
    end
    chk("R5 step errors", errs, 0);

    // R8 strobe: 500 changes per period at down width 0
    start(0, 0);
    errs = 0; pulses = 0; prev = offset;
    for (int m = 1; m <= P; m++) begin
      adv(1);
      if (valid) pulses++;
      if (valid != (offset != prev)) errs++;
      prev = offset;
    end
    chk("R8 strobe match", errs, 0);
    chk("R8 pulse count", pulses, 500);

    // R6 deferred config
    start(0, 3);
    adv(100);
    center = 1; width = 0;
    adv(100);
    chk("R6 old config kept", offset, model(0, 3, 200));
    adv(P - 200);
    chk("R6 boundary nominal", offset, 0);
    adv(256);
    chk("R6 new config", offset, -125);

    // R3 disable mid sweep
    start(0, 3);
    adv(300);
    spread_n = 1;
    @(posedge clk); @(negedge clk);
    chk("R3 one edge later", offset, -1175);
    @(posedge clk); @(negedge clk);
    chk("R3 offset zero", offset, 0);
    chk("R3 spread_on low", spread_on, 0);

    // R9 reference passthrough in both states
    errs = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      spread_n = i[2]; ref_in = i[0];
      #1;
      if (ref_out != ref_in) errs++;
    end
    chk("R9 ref passthrough", errs, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule